// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with Periodic Interrupt

This block is the time base of a real-time clock. A binary divider chain advances once for every system-clock cycle in which the 32.768 kHz oscillator enable is high. The rising edge of its top stage is the 1 Hz strobe that starts the calendar update. A three-bit mode field lets the chain run, holds it at zero so that software can set the time precisely, or stops the oscillator so that the chain keeps its count. When the chain leaves the held-at-zero state, the first 1 Hz strobe comes half a second later.

A four-bit rate field selects one stage of the same chain. Each rising edge of that stage sets a sticky periodic flag. A status-read strobe clears the flag. The interrupt output carries the flag only while the enable bit is set. Software programs the block through a two-address byte write port.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, the control byte and the enable byte are zero, so the mode is 000 (oscillator stopped) and the rate is 0000. tick_1hz, pflag and irq are all low.
- R2: A write to wr_addr 0 loads wr_data[6:4] as the divider mode and wr_data[3:0] as the rate. A write to wr_addr 1 loads wr_data[6] as the interrupt enable. The new value takes effect from the clock edge after the write edge.
- R3: In mode 010 the chain advances by one on each clock where osc_en is high. tick_1hz is a one-clock pulse at every rising edge of stage 15. The first pulse comes 16384 oscillator ticks after the chain leaves the held-at-zero state, and later pulses come every 32768 ticks.
- R4: In modes 000 and 001 the chain keeps its count and produces neither tick nor flag. When mode 010 returns, counting continues from the kept count.
- R5: In modes 011 and 100 to 111 the chain is held at zero and produces neither tick nor flag.
- R6: For rate values 0011 to 1111 the flag sets every 2^(rate-1) oscillator ticks. Rate 0001 gives 128 ticks and rate 0010 gives 256 ticks. Starting from a zeroed chain, the first set comes after half a period.
- R7: Rate 0000 never sets the flag.
- R8: A cycle with rd_stat high clears pflag. If a tap edge falls in the same cycle, the flag stays set.
- R9: irq is high exactly when pflag is high and the enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-cycle enable for each 32.768 kHz oscillator tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control byte, 1 selects the enable byte |
| wr_data | input | 8 | Write data |
| rd_stat | input | 1 | Status-read strobe that clears the periodic flag |
| tick_1hz | output | 1 | One-clock update strobe, once per second |
| pflag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Periodic interrupt request |

## Verification
A tap edge that sets the periodic flag and a status read that clears it can land on the same clock edge. The bench runs the fastest rate, which sets the flag every four ticks. It counts edges from the start of the run so that rd_stat is high exactly on a setting edge. It then expects pflag to stay high, and to fall after a lone read one cycle later. The rate sweep, the mode tests and the 1 Hz timing are judged against edge counts computed from the period formulas.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        DIV_STOP  = 2'd0,
        DIV_RUN   = 2'd1,
        DIV_CLEAR = 2'd2
    } div_mode_e;

    localparam int LOW_TAP = 6;

    function automatic div_mode_e decode_mode(input logic [2:0] code);
        if (code == 3'b010)
            return DIV_RUN;
        else if (code[2:1] == 2'b00)
            return DIV_STOP;
        else
            return DIV_CLEAR;
    endfunction

    function automatic int tap_index(input int code);
        if (code == 1) return LOW_TAP;
        if (code == 2) return LOW_TAP + 1;
        return code - 2;
    endfunction

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RS_W   = 4,
    parameter int MODE_W = 3,
    parameter int PIE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output div_mode_e         mode,
    output logic [RS_W-1:0]   rate_sel,
    output logic              pie
);
    localparam int MODE_LSB = RS_W;
    localparam int MODE_MSB = RS_W + MODE_W - 1;

    typedef struct packed {
        logic [MODE_W-1:0] dv;
        logic [RS_W-1:0]   rs;
        logic              pie;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && !wr_addr) begin
            regs_d.dv = wr_data[MODE_MSB:MODE_LSB];
            regs_d.rs = wr_data[RS_W-1:0];
        end
        if (wr_en && wr_addr)
            regs_d.pie = wr_data[PIE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    logic unused_data;
    assign unused_data = ^wr_data;

    assign mode     = decode_mode(regs_q.dv);
    assign rate_sel = regs_q.rs;
    assign pie      = regs_q.pie;

endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
    import rtc_pkg::*;
#(
    parameter int CHAIN_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_en,
    input  div_mode_e          mode,
    output logic [CHAIN_W-1:0] rise,
    output logic               tick
);
    typedef struct packed {
        logic [CHAIN_W-1:0] cnt;
        logic               tick;
    } div_t;

    div_t div_d, div_q;
    logic               adv;
    logic [CHAIN_W-1:0] inc;

    assign adv = (mode == DIV_RUN) && osc_en;
    assign inc = div_q.cnt + CHAIN_W'(1);

    for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
        assign rise[i] = adv && !div_q.cnt[i] && inc[i];
    end

    always_comb begin
        div_d      = div_q;
        div_d.tick = rise[CHAIN_W-1];
        unique case (mode)
            DIV_RUN:   if (osc_en) div_d.cnt = inc;
            DIV_CLEAR: div_d.cnt = '0;
            default:   div_d.cnt = div_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = div_q.tick;

    p_stop_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DIV_STOP) |=> $stable(div_q.cnt));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DIV_CLEAR) |=> (div_q.cnt == '0) && !div_q.tick);

    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.tick |=> !div_q.tick);

endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
    import rtc_pkg::*;
#(
    parameter int CHAIN_W = 15,
    parameter int RS_W    = 4
) (
    input  logic [CHAIN_W-1:0] rise,
    input  logic [RS_W-1:0]    rate_sel,
    output logic               hit
);
    localparam int N_CODES = 1 << RS_W;

    logic [N_CODES-1:0] sel;

    assign sel[0] = 1'b0;

    for (genvar c = 1; c < N_CODES; c++) begin : g_code
        localparam int IDX = tap_index(c);
        if (IDX < CHAIN_W) begin : g_on
            assign sel[c] = (rate_sel == RS_W'(c)) && rise[IDX];
        end else begin : g_off
            assign sel[c] = 1'b0;
        end
    end

    logic unused_rise;
    assign unused_rise = ^rise;

    assign hit = |sel;

endmodule

// File: rtl/rtc_pirq.sv
module rtc_pirq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_stat,
    input  logic pie,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } pf_t;

    pf_t pf_d, pf_q;

    always_comb begin
        pf_d = pf_q;
        if (hit)          pf_d.flag = 1'b1;
        else if (rd_stat) pf_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pf_q <= '0;
        else        pf_q <= pf_d;
    end

    assign flag = pf_q.flag;
    assign irq  = pf_q.flag && pie;

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !hit) |=> !flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int CHAIN_W = 15,
    parameter int RS_W    = 4,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stat,
    output logic              tick_1hz,
    output logic              pflag,
    output logic              irq
);
    div_mode_e          mode;
    logic [RS_W-1:0]    rate_sel;
    logic               pie;
    logic [CHAIN_W-1:0] rise;
    logic               hit;

    rtc_ctrl_regs #(.DATA_W(DATA_W), .RS_W(RS_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode     (mode),
        .rate_sel (rate_sel),
        .pie      (pie)
    );

    rtc_divider #(.CHAIN_W(CHAIN_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .mode   (mode),
        .rise   (rise),
        .tick   (tick_1hz)
    );

    rtc_tap_sel #(.CHAIN_W(CHAIN_W), .RS_W(RS_W)) i_tap (
        .rise     (rise),
        .rate_sel (rate_sel),
        .hit      (hit)
    );

    rtc_pirq i_pirq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .rd_stat (rd_stat),
        .pie     (pie),
        .flag    (pflag),
        .irq     (irq)
    );

    p_rate_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0 && !pflag) |=> !pflag);

    p_stop_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DIV_STOP) |=> !tick_1hz);

endmodule

// File: tb/test_rtc_prescaler.sv
module test_rtc_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stat = 1'b0;
    logic       tick_1hz, pflag, irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_prescaler i_rtc_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_stat  (rd_stat),
        .tick_1hz (tick_1hz),
        .pflag    (pflag),
        .irq      (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    // called at a negedge, returns at the negedge after the write edge
    task automatic wr(input bit a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        rd_stat = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stat = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // count posedges until sig (0 flag, 1 tick) is seen high
    task automatic wait_for(input bit use_tick, input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!(use_tick ? tick_1hz : pflag) && n < limit);
    endtask

    // zero the chain, clear the flag, then start normal mode with rate rs
    task automatic restart(input logic [3:0] rs);
        wr(1'b0, {1'b0, 3'b110, rs});
        rd();
        wr(1'b0, {1'b0, 3'b010, rs});
    endtask

    initial begin
        int n, idx;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!tick_1hz && !pflag && !irq, "R1 outputs after reset", {tick_1hz, pflag, irq}, 0);
        idle(300);
        check(!tick_1hz && !pflag, "R1 stopped mode quiet", pflag, 0);

        // R6/R2: sweep all nonzero rates, enable off
        for (int rs = 1; rs < 16; rs++) begin
            idx = (rs >= 3) ? rs - 2 : rs + 5;
            restart(4'(rs));
            wait_for(1'b0, 40000, n);
            check(n == (1 << idx), $sformatf("R6 first set rate %0d", rs), n, 1 << idx);
            check(!irq, "R9 irq gated off", irq, 0);
            rd_stat = 1'b1;
            @(posedge clk);
            n = 1;
            @(negedge clk);
            rd_stat = 1'b0;
            check(!pflag, "R8 read clears flag", pflag, 0);
            while (!pflag && n < 40000) begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end
            check(n == (2 << idx), $sformatf("R6 period rate %0d", rs), n, 2 << idx);
        end

        // R8 set and read on the same edge, R9 gating
        wr(1'b1, 8'h40);
        restart(4'd3);
        idle(5);
        rd_stat = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stat = 1'b0;
        check(pflag, "R8 set wins over read", pflag, 1);
        check(irq, "R9 irq follows flag", irq, 1);
        rd();
        check(!pflag && !irq, "R8 lone read clears", pflag, 0);
        wait_for(1'b0, 100, n);
        wr(1'b1, 8'h00);
        check(pflag && !irq, "R9 enable cleared masks irq", irq, 0);
        wr(1'b1, 8'h40);
        check(irq, "R2 enable write", irq, 1);

        // R7 rate zero
        restart(4'd0);
        idle(600);
        check(!pflag && !irq, "R7 rate zero quiet", pflag, 0);

        // R4 stop mode keeps count
        restart(4'd15);
        idle(3000);
        wr(1'b0, {1'b0, 3'b001, 4'd15});
        idle(2000);
        check(!pflag, "R4 no flag while stopped", pflag, 0);
        wr(1'b0, {1'b0, 3'b010, 4'd15});
        wait_for(1'b0, 20000, n);
        check(n == 8192 - 3001, "R4 resume from kept count", n, 8192 - 3001);

        // R5 hold-at-zero
        restart(4'd15);
        idle(3000);
        wr(1'b0, {1'b0, 3'b111, 4'd15});
        idle(2000);
        check(!pflag, "R5 no flag while held", pflag, 0);
        wr(1'b0, {1'b0, 3'b010, 4'd15});
        wait_for(1'b0, 20000, n);
        check(n == 8192, "R5 restart from zero", n, 8192);

        // R3 update strobe
        restart(4'd0);
        wait_for(1'b1, 40000, n);
        check(n == 16384, "R3 first tick half second", n, 16384);
        @(posedge clk);
        @(negedge clk);
        check(!tick_1hz, "R3 tick one clock wide", tick_1hz, 0);
        wait_for(1'b1, 40000, n);
        check(n == 32767, "R3 tick period", n + 1, 32768);

        done = 1;
        finish_run();
    end

endmodule